// File: doc/BRIEF.md
# Sequential Minifloat Multiplier

This block multiplies two 12-bit floating-point numbers. Each word holds a sign bit, a 4-bit biased exponent and a 7-bit stored fraction. A clocked state machine walks one operation through fixed steps: it captures the operands, splits them into fields, multiplies the significands, normalizes the product and packs the result word. The state machine is the top module. The significand product comes from an instantiated combinational Booth multiplier; the design has no built-in multiply operator.

A client pulses `start` with both operands valid while the block is idle. A fixed number of cycles later, `done` is high for one cycle and `result` holds the product. `result` keeps that value until the next operation overwrites it. Rounding is by truncation. The format has no subnormal, infinity or NaN encodings. An out-of-range exponent saturates to the largest finite magnitude or flushes to zero.

Top module: `fpm_seq_mul`

## Requirements
- R1: The result sign, bit 11, is the XOR of the operand signs (bit 11 of each operand). This holds for all results, including zero and saturated ones.
- R2: Operand fields are sign [11], exponent [10:7] and fraction [6:0]. The exponent bias is 7. A nonzero operand has the value 1.fraction × 2^(exponent−7); exponent 0 with a nonzero fraction is an ordinary normal number. When the 16-bit significand product has bit 15 clear, the result exponent is Ea+Eb−7 and the result fraction is product bits 13:7.
- R3: When product bit 15 is set, the result fraction is product bits 14:8 and the result exponent is Ea+Eb−7+1.
- R4: Product bits below the kept fraction are dropped, which is truncation toward zero in magnitude.
- R5: An operand with exponent 0 and fraction 0 is zero. If either operand is zero, the result is a signed zero: bits 10:0 are 0 and the sign follows R1.
- R6: If the final exponent exceeds 15, bits 10:0 of the result are all ones, the largest finite magnitude.
- R7: If the final exponent is below 0, bits 10:0 of the result are 0. A final exponent of exactly 0 is kept.
- R8: `done` is high for exactly one cycle. That cycle starts on the 4th rising edge after the edge that accepted `start`. `result` then holds its value until the next accepted operation completes.
- R9: `start` is accepted only while the block is idle. A `start` seen during any later step, including the `done` cycle, is ignored: it produces no extra result and does not change the operation in flight.
- R10: A synchronous reset forces `done` low and `result` to 0, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, sampled only while idle |
| op_a | input | 12 | First operand, sign/exponent/fraction |
| op_b | input | 12 | Second operand, sign/exponent/fraction |
| result | output | 12 | Packed product, held until the next completion |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its default parameters: a 4-bit exponent, a 7-bit fraction and a bias of 7. With these values the Booth multiplier sees 8-bit significands and the exponent stage works in 6-bit signed arithmetic. This makes the exponent edges easy to reach with hand-picked operands: a final exponent of exactly 15 or 0, one step past either edge, and a normalization carry that pushes the exponent across the top. Random operands fill in the remaining product patterns.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_MUL,
      ST_NORM,
      ST_PACK,
      ST_DONE
   } fpm_state_e;

endpackage

// File: rtl/fpm_en_reg.sv
module fpm_en_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_width_chk
      $error("fpm_en_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en)
         q <= d;
   end

endmodule

// File: rtl/fpm_booth_mul.sv
// Radix-2 Booth multiplier for unsigned factors. Each factor is widened by a
// zero bit so the signed recoding yields the unsigned product.
module fpm_booth_mul #(
   parameter int N = 8
) (
   input  logic [N-1:0]   fac_a,
   input  logic [N-1:0]   fac_b,
   output logic [2*N-1:0] prod
);

   localparam int M  = N + 1;
   localparam int PW = 2 * M;

   if (N < 2) begin : g_n_chk
      $error("fpm_booth_mul: N must be at least 2");
   end

   logic [M:0]           rec;
   logic signed [PW-1:0] mcand;
   logic signed [PW-1:0] pp [M];
   logic signed [PW-1:0] acc;
   logic [PW-2*N-1:0]    unused_hi;

   assign rec   = {1'b0, fac_b, 1'b0};
   assign mcand = $signed({{(PW-N){1'b0}}, fac_a});

   for (genvar i = 0; i < M; i++) begin : g_pp
      assign pp[i] = (rec[i+1:i] == 2'b01) ?  (mcand <<< i) :
                     (rec[i+1:i] == 2'b10) ? -(mcand <<< i) : '0;
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < M; k++)
         acc = acc + pp[k];
   end

   assign prod      = acc[2*N-1:0];
   assign unused_hi = acc[PW-1:2*N];

endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize #(
   parameter int MAN_W = 7,
   parameter int EW    = 6
) (
   input  logic [2*MAN_W+1:0]   prod,
   input  logic signed [EW-1:0] exp_in,
   output logic [MAN_W-1:0]     man_out,
   output logic signed [EW-1:0] exp_out
);

   localparam int PROD_W = 2 * MAN_W + 2;

   logic             carry;
   logic [MAN_W-1:0] unused_lo;

   assign carry     = prod[PROD_W-1];
   assign man_out   = carry ? prod[PROD_W-2 -: MAN_W] : prod[PROD_W-3 -: MAN_W];
   assign exp_out   = carry ? exp_in + EW'(1) : exp_in;
   assign unused_lo = prod[MAN_W-1:0];

endmodule

// File: rtl/fpm_pack.sv
module fpm_pack #(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7,
   parameter int EW    = EXP_W + 2
) (
   input  logic                     sign,
   input  logic                     zero,
   input  logic signed [EW-1:0]     exp_in,
   input  logic [MAN_W-1:0]         man,
   output logic [EXP_W+MAN_W:0]     word
);

   localparam int MAX_E = (1 << EXP_W) - 1;

   always_comb begin
      if (zero || exp_in < 0)
         word = {sign, {(EXP_W+MAN_W){1'b0}}};
      else if (exp_in > $signed(EW'(MAX_E)))
         word = {sign, {(EXP_W+MAN_W){1'b1}}};
      else
         word = {sign, exp_in[EXP_W-1:0], man};
   end

endmodule

// File: rtl/fpm_seq_mul.sv
module fpm_seq_mul
   import fpm_pkg::*;
#(
   parameter int EXP_W = 4,
   parameter int MAN_W = 7,
   parameter int BIAS  = 7
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [EXP_W+MAN_W:0]   op_a,
   input  logic [EXP_W+MAN_W:0]   op_b,
   output logic [EXP_W+MAN_W:0]   result,
   output logic                   done
);

   localparam int W      = 1 + EXP_W + MAN_W;
   localparam int SIG_W  = MAN_W + 1;
   localparam int PROD_W = 2 * SIG_W;
   localparam int EW     = EXP_W + 2;
   localparam int MAX_E  = (1 << EXP_W) - 1;

   if (EXP_W < 2 || MAN_W < 1 || BIAS < 1 || BIAS > MAX_E) begin : g_param_chk
      $error("fpm_seq_mul: unsupported EXP_W/MAN_W/BIAS combination");
   end

   fpm_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (start) state_nx = ST_LOAD;
         ST_LOAD: state_nx = ST_MUL;
         ST_MUL:  state_nx = ST_NORM;
         ST_NORM: state_nx = ST_PACK;
         ST_PACK: state_nx = ST_DONE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state <= ST_IDLE;
      else
         state <= state_nx;
   end

   // capture
   logic [W-1:0] opa_q, opb_q;
   logic         en_cap;
   assign en_cap = (state == ST_IDLE) && start;

   fpm_en_reg #(.WIDTH(W)) u_opa (.clk, .rst, .en(en_cap), .d(op_a), .q(opa_q));
   fpm_en_reg #(.WIDTH(W)) u_opb (.clk, .rst, .en(en_cap), .d(op_b), .q(opb_q));

   // unpack, sign, exponent sum
   logic [EXP_W-1:0]     a_e, b_e;
   logic [MAN_W-1:0]     a_m, b_m;
   logic signed [EW-1:0] esum_d, esum_q;
   logic                 sign_d, sign_q, zero_d, zero_q;
   logic [SIG_W-1:0]     siga_q, sigb_q;

   assign a_e    = opa_q[W-2 -: EXP_W];
   assign b_e    = opb_q[W-2 -: EXP_W];
   assign a_m    = opa_q[MAN_W-1:0];
   assign b_m    = opb_q[MAN_W-1:0];
   assign sign_d = opa_q[W-1] ^ opb_q[W-1];
   assign zero_d = (a_e == '0 && a_m == '0) || (b_e == '0 && b_m == '0);
   assign esum_d = EW'(a_e) + EW'(b_e) - EW'(BIAS);

   logic en_load;
   assign en_load = (state == ST_LOAD);

   fpm_en_reg #(.WIDTH(1))     u_sign (.clk, .rst, .en(en_load), .d(sign_d), .q(sign_q));
   fpm_en_reg #(.WIDTH(1))     u_zero (.clk, .rst, .en(en_load), .d(zero_d), .q(zero_q));
   fpm_en_reg #(.WIDTH(EW))    u_esum (.clk, .rst, .en(en_load), .d(esum_d), .q(esum_q));
   fpm_en_reg #(.WIDTH(SIG_W)) u_siga (.clk, .rst, .en(en_load), .d({1'b1, a_m}), .q(siga_q));
   fpm_en_reg #(.WIDTH(SIG_W)) u_sigb (.clk, .rst, .en(en_load), .d({1'b1, b_m}), .q(sigb_q));

   // significand product
   logic [PROD_W-1:0] prod_d, prod_q;

   fpm_booth_mul #(.N(SIG_W)) u_booth (.fac_a(siga_q), .fac_b(sigb_q), .prod(prod_d));
   fpm_en_reg #(.WIDTH(PROD_W)) u_prod (.clk, .rst, .en(state == ST_MUL), .d(prod_d), .q(prod_q));

   // normalize
   logic [MAN_W-1:0]     man_d, man_q;
   logic signed [EW-1:0] expn_d, expn_q;

   fpm_normalize #(.MAN_W(MAN_W), .EW(EW)) u_norm (
      .prod(prod_q), .exp_in(esum_q), .man_out(man_d), .exp_out(expn_d));

   fpm_en_reg #(.WIDTH(MAN_W)) u_man  (.clk, .rst, .en(state == ST_NORM), .d(man_d), .q(man_q));
   fpm_en_reg #(.WIDTH(EW))    u_expn (.clk, .rst, .en(state == ST_NORM), .d(expn_d), .q(expn_q));

   // pack with saturation
   logic [W-1:0] word_d;

   fpm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EW(EW)) u_pack (
      .sign(sign_q), .zero(zero_q), .exp_in(expn_q), .man(man_q), .word(word_d));

   fpm_en_reg #(.WIDTH(W)) u_res (.clk, .rst, .en(state == ST_PACK), .d(word_d), .q(result));

   assign done = (state == ST_DONE);

   // R10
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!done && result == '0));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q)));

   // R1
   sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PACK) |=> (result[W-1] == $past(sign_q)));

   // R5
   zero_out_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PACK && zero_q) |=> (result[W-2:0] == '0));

   // R3
   carry_exp_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_NORM && prod_q[PROD_W-1]) |=> (expn_q == $past(esum_q) + EW'(1)));

   // R6
   saturate_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PACK && !zero_q && expn_q > $signed(EW'(MAX_E)))
      |=> (result[W-2:0] == '1));

endmodule

// File: tb/fpm_seq_mul_test.sv
`timescale 1ns/1ps
module fpm_seq_mul_test;

   localparam int EW = 4;
   localparam int MW = 7;
   localparam int BS = 7;
   localparam int W  = 1 + EW + MW;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] result;
   logic         done;

   always #2.5 clk = ~clk;

   fpm_seq_mul #(.EXP_W(EW), .MAN_W(MW), .BIAS(BS)) uut (
      .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
      .result(result), .done(done));

   int          checks = 0;
   int          fails = 0;
   int unsigned cyc = 0;
   int          pushed = 0;
   int          seen = 0;
   logic [W-1:0] exp_q [$];
   string        tag_q [$];
   int unsigned  stc_q [$];
   logic         last_done = 1'b0;
   logic [W-1:0] last_res = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // expected product from the requirements (R1..R7)
   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
      logic       s;
      int         ea, eb, e;
      int         p;
      logic [MW-1:0] m;
      s  = a[W-1] ^ b[W-1];
      ea = int'(a[W-2 -: EW]);
      eb = int'(b[W-2 -: EW]);
      if ((ea == 0 && a[MW-1:0] == 0) || (eb == 0 && b[MW-1:0] == 0))
         return {s, {(W-1){1'b0}}};
      p = int'({1'b1, a[MW-1:0]}) * int'({1'b1, b[MW-1:0]});
      e = ea + eb - BS;
      if (p >= (1 << (2*MW+1))) begin
         m = MW'(p >> (MW+1));
         e = e + 1;
      end else begin
         m = MW'(p >> MW);
      end
      if (e > (1 << EW) - 1) return {s, {(W-1){1'b1}}};
      if (e < 0)             return {s, {(W-1){1'b0}}};
      return {s, EW'(e), m};
   endfunction

   // monitor
   always @(negedge clk) begin
      logic [W-1:0] e;
      string        t;
      int unsigned  s;
      if (!rst && done) begin
         if (last_done) check(1'b0, "R8 done wider than one cycle", 1, 0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected done", seen + 1, pushed);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            s = stc_q.pop_front();
            check(result == e, t, result, e);
            check(cyc - s == 4, "R8 latency", cyc - s, 4);
         end
         seen++;
         last_res = result;
      end
      last_done = done;
   end

   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      @(negedge clk);
      exp_q.push_back(model(a, b));
      tag_q.push_back(tag);
      stc_q.push_back(cyc + 1);
      pushed++;
      op_a = a; op_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", seen, pushed);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      check(done == 1'b0, "R10 done after reset", done, 0);
      check(result == '0, "R10 result after reset", result, 0);

      issue(12'h380, 12'h380, "R2 one times one");
      issue(12'h3C0, 12'h3C0, "R3 carry 1.5*1.5");
      check(last_res == 12'h410, "R3 hand value 2.25", last_res, 12'h410);
      issue(12'hB80, 12'h380, "R1 negative times positive");
      issue(12'hB80, 12'hBC0, "R1 negative times negative");
      issue(12'h3FF, 12'h3FF, "R4 truncation of low bits");
      issue(12'h3C1, 12'h381, "R4 truncation no carry");
      issue(12'h001, 12'h380, "R2 exponent zero nonzero fraction");
      issue(12'h000, 12'h7FF, "R5 zero operand a");
      issue(12'h800, 12'h380, "R5 negative zero");
      issue(12'h380, 12'h800, "R5 zero operand b sign");
      issue(12'hFFF, 12'h000, "R5 zero against max");
      issue(12'h7FF, 12'h7FF, "R6 overflow saturates");
      issue(12'hFFF, 12'h7FF, "R6 negative saturation");
      issue(12'h780, 12'h380, "R6 exponent exactly 15 kept");
      issue(12'h7C0, 12'h3C0, "R6 carry pushes past 15");
      issue(12'h080, 12'h080, "R7 underflow flush");
      issue(12'h180, 12'h180, "R7 exponent -1 flush");
      issue(12'h1C0, 12'h1C0, "R7 carry lifts -1 to 0");
      issue(12'h880, 12'h080, "R7 negative underflow");

      // R8 result holds after done
      repeat (3) @(negedge clk);
      check(result == last_res, "R8 result hold", result, last_res);

      // R9 start while busy is ignored (mid-operation and in done cycle)
      @(negedge clk);
      exp_q.push_back(model(12'h3A5, 12'h44C));
      tag_q.push_back("R9 in-flight operands kept");
      stc_q.push_back(cyc + 1);
      pushed++;
      op_a = 12'h3A5; op_b = 12'h44C; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op_a = 12'h7FF; op_b = 12'h7FF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      check(seen == pushed, "R9 no extra done", seen, pushed);

      // R10 reset aborts an operation
      @(negedge clk);
      op_a = 12'h7FF; op_b = 12'h7FF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(result == '0, "R10 reset clears result", result, 0);
      check(done == 1'b0, "R10 reset clears done", done, 0);
      repeat (8) @(negedge clk);
      check(seen == pushed, "R10 aborted op gives no done", seen, pushed);

      // mixed operands, R1..R7 via the model
      for (int n = 0; n < 200; n++) begin
         issue(W'($urandom), W'($urandom), "R2 random operands");
      end

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R8 every request completed", exp_q.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule